// File: doc/BRIEF.md
# Pipe Interrupt Aggregator

This block gathers interrupt events from a set of data-movement pipes and from the shared controller core. It folds them into a single active-high, level-sensitive interrupt line for one execution environment. Every event arrives as a one-cycle pulse and is latched into a sticky status bit. Each status bank has an enable register that selects which latched bits may request service, and a write-one-to-clear register that software uses to acknowledge them.

The state is held on two levels. At the lower level, each pipe has six status bits and the controller core has four. At the upper level, a source word summarises them: bit i stands for pipe i and bit 31 stands for the core. A mask register gates each source bit before the final OR. Software reaches all registers through a flat word-address port. Writes are single-cycle, and reads are combinational from the address.

Top module: `irq_aggregator`

Register map (word addresses):
- 0x00: core status (read only)
- 0x01: core enable
- 0x02: core clear (write one to clear)
- 0x03: masked source
- 0x04: mask
- 0x05: unmasked source
- 0x10 + 4*i + {0, 1, 2}: pipe i status, enable and clear

## Requirements
- R1: A pulse on `pipe_evt_i[6*i+b]` sets bit b of pipe i's status (address 0x10+4*i) at the next clock edge. The bit stays set until it is cleared. The bit meanings are:
  - bit 0: processed descriptor
  - bit 1: timer
  - bit 2: wake
  - bit 3: out of descriptors
  - bit 4: error
  - bit 5: transfer end
- R2: A write to pipe i's clear register (0x10+4*i+2) clears exactly the status bits written as 1 and leaves the other bits unchanged.
- R3: Pipe i's enable register (0x10+4*i+1) uses the status bit layout. Source bit i is 1 exactly when pipe i has a status bit that is both set and enabled.
- R4: Core status (0x00) holds four bits:
  - bit 1: bus response error, set by `core_evt_i[0]`
  - bit 2: error, set by `core_evt_i[1]`
  - bit 3: empty, set by `core_evt_i[2]`
  - bit 4: timer, set by `core_evt_i[3]`

  Core enable (0x01) and core clear (0x02) use the same positions. All other bits read 0.
- R5: Source bit 31 is 1 exactly when the core has a status bit that is both set and enabled.
- R6: The masked source word (0x03) is the unmasked source ANDed with the mask (0x04). `irq_o` is high exactly when the masked source word is nonzero. A mask of 0 silences the output.
- R7: The unmasked source word (0x05) shows source bits 0..N-1 and 31 regardless of the mask.
- R8: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R9: After reset, all status, enable and mask registers read 0 and `irq_o` is low.
- R10: Writes to a status register (0x00 or 0x10+4*i) change nothing.
- R11: Only mask bits 0..N-1 and 31 are storable. Clear registers, unused addresses and addresses of pipes at or above N read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| addr_i | input | 8 | register word address |
| wr_en_i | input | 1 | write strobe for one cycle |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for `addr_i` |
| pipe_evt_i | input | 6*NUM_PIPES | event pulses, 6 per pipe |
| core_evt_i | input | 4 | controller core event pulses |
| irq_o | output | 1 | aggregated interrupt, level high |

## Verification
The bench builds the block with three pipes, so the pipe count is not a power of two. With that count, the mask width check and the reads of an absent fourth pipe's addresses both exercise the unused source positions 3 to 30. Three pipes are enough to place an event, an enable and a clear on different pipes while the core bank drives source bit 31 at the same time.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 32;
  localparam int PIPE_BITS   = 6;
  localparam int CORE_BITS   = 4;
  localparam int CORE_LSB    = 1;
  localparam int PIPE_STRIDE = 4;

  localparam logic [ADDR_W-1:0] A_CORE_STAT = 8'h00;
  localparam logic [ADDR_W-1:0] A_CORE_EN   = 8'h01;
  localparam logic [ADDR_W-1:0] A_CORE_CLR  = 8'h02;
  localparam logic [ADDR_W-1:0] A_SRC       = 8'h03;
  localparam logic [ADDR_W-1:0] A_MASK      = 8'h04;
  localparam logic [ADDR_W-1:0] A_SRC_RAW   = 8'h05;
  localparam logic [ADDR_W-1:0] A_PIPE_BASE = 8'h10;

  typedef enum logic [1:0] {
    PR_STAT = 2'd0,
    PR_EN   = 2'd1,
    PR_CLR  = 2'd2,
    PR_RSVD = 2'd3
  } pipe_reg_e;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_CORE_STAT,
    RS_CORE_EN,
    RS_SRC,
    RS_MASK,
    RS_SRC_RAW,
    RS_PIPE_STAT,
    RS_PIPE_EN
  } rd_sel_e;
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         en_wr_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         pend_o
);
  logic [W-1:0] stat_q, en_q, clr_mask;

  assign clr_mask = clr_wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      // set wins over a same-cycle clear
      stat_q <= (stat_q & ~clr_mask) | evt_i;
      if (en_wr_i) en_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = |(stat_q & en_q);

  p_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr_i |=> (($past(stat_o) & ~stat_o) == '0));

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i |=> ((stat_o & $past(wdata_i & ~evt_i)) == '0));
endmodule

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_agg_pkg::*;
#(
  parameter int NUM_PIPES = 8,
  parameter int IDX_W     = 3
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  output rd_sel_e              rd_sel_o,
  output logic [IDX_W-1:0]     pipe_idx_o,
  output logic                 core_en_wr_o,
  output logic                 core_clr_wr_o,
  output logic                 mask_wr_o,
  output logic [NUM_PIPES-1:0] pipe_en_wr_o,
  output logic [NUM_PIPES-1:0] pipe_clr_wr_o
);
  localparam int SLOT_W = ADDR_W - 2;

  logic [ADDR_W-1:0] off;
  logic [SLOT_W-1:0] slot;
  pipe_reg_e         preg;
  logic              in_pipe;

  assign off     = addr_i - A_PIPE_BASE;
  assign slot    = off[ADDR_W-1:2];
  assign preg    = pipe_reg_e'(off[1:0]);
  assign in_pipe = (addr_i >= A_PIPE_BASE) && (int'(slot) < NUM_PIPES);
  assign pipe_idx_o = slot[IDX_W-1:0];

  assign core_en_wr_o  = wr_en_i && (addr_i == A_CORE_EN);
  assign core_clr_wr_o = wr_en_i && (addr_i == A_CORE_CLR);
  assign mask_wr_o     = wr_en_i && (addr_i == A_MASK);

  for (genvar g = 0; g < NUM_PIPES; g++) begin : g_wr
    assign pipe_en_wr_o[g]  = wr_en_i && in_pipe && (int'(slot) == g) && (preg == PR_EN);
    assign pipe_clr_wr_o[g] = wr_en_i && in_pipe && (int'(slot) == g) && (preg == PR_CLR);
  end

  always_comb begin
    rd_sel_o = RS_NONE;
    if (in_pipe) begin
      if (preg == PR_STAT)    rd_sel_o = RS_PIPE_STAT;
      else if (preg == PR_EN) rd_sel_o = RS_PIPE_EN;
    end else begin
      case (addr_i)
        A_CORE_STAT: rd_sel_o = RS_CORE_STAT;
        A_CORE_EN:   rd_sel_o = RS_CORE_EN;
        A_SRC:       rd_sel_o = RS_SRC;
        A_MASK:      rd_sel_o = RS_MASK;
        A_SRC_RAW:   rd_sel_o = RS_SRC_RAW;
        default:     rd_sel_o = RS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_PIPES = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           wr_en_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  input  logic [NUM_PIPES*PIPE_BITS-1:0] pipe_evt_i,
  input  logic [CORE_BITS-1:0]           core_evt_i,
  output logic                           irq_o
);
  localparam int IDX_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1;
  localparam logic [DATA_W-1:0] SRC_VALID =
    ((DATA_W'(1) << NUM_PIPES) - DATA_W'(1)) | (DATA_W'(1) << (DATA_W-1));

  rd_sel_e              rd_sel;
  logic [IDX_W-1:0]     pipe_idx;
  logic                 core_en_wr, core_clr_wr, mask_wr;
  logic [NUM_PIPES-1:0] pipe_en_wr, pipe_clr_wr, pipe_pend;
  logic [PIPE_BITS-1:0] pipe_stat [NUM_PIPES];
  logic [PIPE_BITS-1:0] pipe_en   [NUM_PIPES];
  logic [CORE_BITS-1:0] core_stat, core_en;
  logic                 core_pend;
  logic [DATA_W-1:0]    mask_q, src_raw, src;

  irq_addr_dec #(.NUM_PIPES(NUM_PIPES), .IDX_W(IDX_W)) i_dec (
    .addr_i        (addr_i),
    .wr_en_i       (wr_en_i),
    .rd_sel_o      (rd_sel),
    .pipe_idx_o    (pipe_idx),
    .core_en_wr_o  (core_en_wr),
    .core_clr_wr_o (core_clr_wr),
    .mask_wr_o     (mask_wr),
    .pipe_en_wr_o  (pipe_en_wr),
    .pipe_clr_wr_o (pipe_clr_wr)
  );

  for (genvar g = 0; g < NUM_PIPES; g++) begin : g_pipe
    irq_stat_bank #(.W(PIPE_BITS)) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (pipe_evt_i[g*PIPE_BITS +: PIPE_BITS]),
      .en_wr_i  (pipe_en_wr[g]),
      .clr_wr_i (pipe_clr_wr[g]),
      .wdata_i  (wdata_i[PIPE_BITS-1:0]),
      .stat_o   (pipe_stat[g]),
      .en_o     (pipe_en[g]),
      .pend_o   (pipe_pend[g])
    );
  end

  irq_stat_bank #(.W(CORE_BITS)) i_core_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (core_evt_i),
    .en_wr_i  (core_en_wr),
    .clr_wr_i (core_clr_wr),
    .wdata_i  (wdata_i[CORE_LSB +: CORE_BITS]),
    .stat_o   (core_stat),
    .en_o     (core_en),
    .pend_o   (core_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_wr) mask_q <= wdata_i & SRC_VALID;
  end

  always_comb begin
    src_raw = '0;
    src_raw[NUM_PIPES-1:0] = pipe_pend;
    src_raw[DATA_W-1] = core_pend;
  end

  assign src   = src_raw & mask_q;
  assign irq_o = |src;

  always_comb begin
    rdata_o = '0;
    case (rd_sel)
      RS_CORE_STAT: rdata_o[CORE_LSB +: CORE_BITS] = core_stat;
      RS_CORE_EN:   rdata_o[CORE_LSB +: CORE_BITS] = core_en;
      RS_SRC:       rdata_o = src;
      RS_MASK:      rdata_o = mask_q;
      RS_SRC_RAW:   rdata_o = src_raw;
      RS_PIPE_STAT: rdata_o[PIPE_BITS-1:0] = pipe_stat[pipe_idx];
      RS_PIPE_EN:   rdata_o[PIPE_BITS-1:0] = pipe_en[pipe_idx];
      default:      rdata_o = '0;
    endcase
  end

  p_mask_gates_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);

  p_irq_has_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (core_pend || (pipe_pend != '0)));

  p_mask_width_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q & ~SRC_VALID) == '0);

  p_core_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_raw[DATA_W-1] |-> ((core_stat & core_en) != '0));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [NP*6-1:0] pipe_evt_i = '0;
  logic [3:0]  core_evt_i = '0;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp_data;
    logic        exp_irq;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator #(.NUM_PIPES(NP)) i_irq_aggregator (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pipe_evt_i(pipe_evt_i),
    .core_evt_i(core_evt_i), .irq_o(irq_o)
  );

  // monitor: compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (rdata_o !== it.exp_data || irq_o !== it.exp_irq) begin
          bad++;
          $display("FAIL %s addr=%h data=%h exp=%h irq=%b exp_irq=%b",
                   it.tag, it.addr, rdata_o, it.exp_data, irq_o, it.exp_irq);
        end
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] d, input logic irq, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr_i = a;
    it.addr = a; it.exp_data = d; it.exp_irq = irq; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  // optional write in the same cycle as the event pulses
  task automatic pulse(input int p, input logic [5:0] pb, input logic [3:0] cb,
                       input logic do_wr, input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    pipe_evt_i = '0;
    if (p >= 0) pipe_evt_i[p*6 +: 6] = pb;
    core_evt_i = cb;
    addr_i = a; wdata_i = d; wr_en_i = do_wr;
    @(posedge clk); #1;
    pipe_evt_i = '0; core_evt_i = '0; wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R9 reset state
    rd(8'h00, 32'h0, 1'b0, "R9 core stat");
    rd(8'h01, 32'h0, 1'b0, "R9 core en");
    rd(8'h04, 32'h0, 1'b0, "R9 mask");
    rd(8'h05, 32'h0, 1'b0, "R9 raw src");
    rd(8'h10, 32'h0, 1'b0, "R9 pipe0 stat");
    rd(8'h11, 32'h0, 1'b0, "R9 pipe0 en");
    // R1 latch and hold
    pulse(1, 6'b010001, 4'h0, 1'b0, 8'h00, 32'h0);
    rd(8'h14, 32'h11, 1'b0, "R1 pipe1 stat");
    rd(8'h05, 32'h0, 1'b0, "R3 not enabled");
    pulse(1, 6'b000010, 4'h0, 1'b0, 8'h00, 32'h0);
    rd(8'h14, 32'h13, 1'b0, "R1 sticky");
    // R3 / R7 enable
    wr(8'h15, 32'h10);
    rd(8'h15, 32'h10, 1'b0, "R3 pipe1 en");
    rd(8'h05, 32'h2, 1'b0, "R7 raw src");
    rd(8'h03, 32'h0, 1'b0, "R6 masked off");
    // R6 mask
    wr(8'h04, 32'h2);
    rd(8'h03, 32'h2, 1'b1, "R6 unmasked src");
    // R2 clear
    wr(8'h16, 32'h10);
    rd(8'h14, 32'h03, 1'b0, "R2 clear one bit");
    rd(8'h05, 32'h0, 1'b0, "R2 source drops");
    // R10 status write ignored
    wr(8'h14, 32'h3F);
    rd(8'h14, 32'h03, 1'b0, "R10 pipe stat ro");
    wr(8'h00, 32'h1E);
    rd(8'h00, 32'h0, 1'b0, "R10 core stat ro");
    rd(8'h16, 32'h0, 1'b0, "R11 clear reads 0");
    // R4 core bank
    pulse(-1, 6'b0, 4'b1000, 1'b0, 8'h00, 32'h0);
    rd(8'h00, 32'h10, 1'b0, "R4 core timer bit4");
    rd(8'h05, 32'h0, 1'b0, "R5 core not enabled");
    wr(8'h01, 32'h1F);
    rd(8'h01, 32'h1E, 1'b0, "R4 core en bits");
    rd(8'h05, 32'h8000_0000, 1'b0, "R5 core source");
    // R11 mask width, R6 output
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h8000_0007, 1'b1, "R11 mask bits");
    rd(8'h03, 32'h8000_0000, 1'b1, "R6 core irq");
    wr(8'h02, 32'h10);
    rd(8'h00, 32'h0, 1'b0, "R4 core clear");
    rd(8'h03, 32'h0, 1'b0, "R6 irq drops");
    // R8 set wins
    wr(8'h19, 32'h20);
    pulse(2, 6'b100000, 4'h0, 1'b1, 8'h1A, 32'h20);
    rd(8'h18, 32'h20, 1'b1, "R8 pipe set wins");
    pulse(-1, 6'b0, 4'b0010, 1'b1, 8'h02, 32'h04);
    rd(8'h00, 32'h04, 1'b1, "R8 core set wins");
    rd(8'h03, 32'h8000_0004, 1'b1, "R6 two sources");
    // R11 absent pipe and gaps
    rd(8'h1C, 32'h0, 1'b1, "R11 pipe3 absent");
    rd(8'h07, 32'h0, 1'b1, "R11 gap addr");
    wr(8'h1A, 32'h20);
    wr(8'h02, 32'h04);
    rd(8'h03, 32'h0, 1'b0, "R6 all cleared");
    wr(8'h04, 32'h0);
    rd(8'h14, 32'h03, 1'b0, "R1 pipe1 kept");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule